// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

Two linked eight-input priority interrupt controllers share one interrupt line to the processor. The first controller takes request lines 0 to 7. The second controller takes lines 8 to 15, and its pending indication feeds line 2 of the first controller instead of an external pin. Each controller has its own mask register and its own vector base. Each controller resolves a winner among its unmasked, latched requests under fixed priority, taking into account which lines are already in service.

The processor sees `cpuInt` and answers with a one-cycle `intAck` pulse. When the first controller's winner is an ordinary line, the block returns that controller's base plus the line index. When the winner is line 2, the block hands the acknowledge down to the second controller in the following cycle, and that controller's base plus its own index is returned. A controller with nothing to give at its acknowledge moment answers with its base plus 7 and marks nothing as in service. A non-specific end-of-interrupt strobe, addressed to one controller, retires that controller's highest-priority in-service line.

Top module: `cascaded_intc`

## Requirements
- R1: After reset, `cpuInt` and `vecValid` are 0, `vecOut` is 0, every mask bit is 0 (all lines enabled), both vector bases are 0 and no request or in-service bit is set.
- R2: A request is latched on a rising edge of its `reqIn` bit (bits 0–7 for the first controller, 8–15 for the second). A level that stays high is not latched again after it has been acknowledged. `reqIn[2]` has no effect.
- R3: Line 2 of the first controller is pending exactly while the second controller has a winner (an unmasked request not blocked by its own in-service bits). It is withdrawn as soon as that is no longer true.
- R4: In each controller, line 0 has the highest priority and line 7 the lowest. A request wins only if it is unmasked and no in-service bit at the same or a higher-priority position is set.
- R5: `cpuInt` is high exactly while the first controller has a winner.
- R6: An `intAck` with an ordinary winner (not line 2) on the first controller gives `vecValid` one cycle later, with `vecOut` = first base + index and `lineOut` = index. That request bit is cleared and its in-service bit is set.
- R7: An `intAck` with winner line 2 sets the first controller's in-service bit 2. The second controller is then acknowledged in the next cycle, and `vecValid` follows two cycles after `intAck` with `vecOut` = second base + slave index (8-bit wrap) and `lineOut` = 8 + slave index.
- R8: If the second controller has no winner in the cycle after a cascaded acknowledge, `vecOut` = second base + 7 and `lineOut` = 15. No in-service bit of the second controller is set, and its requests stay latched.
- R9: An `intAck` while the first controller has no winner gives `vecOut` = first base + 7 and `lineOut` = 7 one cycle later, and sets no in-service bit.
- R10: A mask write (`maskSel` 0 = first, 1 = second; mask bit n = 1 disables line n) applies in the cycle of the write. If it masks the current winner, `cpuInt` falls in that same cycle, including the case where the winner comes through line 2.
- R11: While the second controller has no winner, lower-priority lines of the first controller (3–7) are delivered normally.
- R12: `eoiStb` clears the lowest-index set in-service bit of the controller chosen by `eoiSel` (0 = first, 1 = second).
- R13: An `intAck` that arrives in the cycle while a cascaded acknowledge is being completed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 16 | Request lines; 0–7 first controller, 8–15 second controller |
| maskWe | input | 1 | Mask write strobe |
| maskSel | input | 1 | Mask target: 0 first, 1 second |
| maskData | input | 8 | Mask value, 1 disables the line |
| baseWe | input | 1 | Vector base write strobe |
| baseSel | input | 1 | Base target: 0 first, 1 second |
| baseData | input | 8 | Vector base value |
| eoiStb | input | 1 | Non-specific end-of-interrupt strobe |
| eoiSel | input | 1 | End-of-interrupt target: 0 first, 1 second |
| intAck | input | 1 | Acknowledge pulse from the processor |
| cpuInt | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Returned vector |
| vecValid | output | 1 | One-cycle pulse marking `vecOut` valid |
| lineOut | output | 4 | System line number of the answer (0–15) |

## Verification
The bench builds the block with its defaults: eight lines per controller, 8-bit vectors and the cascade on line 2. With this build, lines 0 and 1 outrank any line of the second controller while lines 3 to 7 lose to it, and the full system numbering 8 to 15 appears on `lineOut`. A base near the top of the 8-bit range shows the vector wrapping. Masks are written in the cycle right after a cascaded acknowledge to reach the spurious answer of the second controller, and `cpuInt` is sampled inside the cycle of a mask write to show that the write takes effect at once.

// File: rtl/dic_pkg.sv
package dic_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_CASC
  } ackState_t;

  // Strobes from control to datapath; at most one is high per cycle.
  typedef struct packed {
    logic takeMaster;
    logic enterCasc;
    logic spurMaster;
    logic takeSlave;
    logic spurSlave;
  } ackStrobe_t;

endpackage

// File: rtl/icResolver.sv
module icResolver #(
  parameter int LINES = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0] req,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] inService,
  output logic             valid,
  output logic [IDX_W-1:0] winIdx
);

  logic             reqFound;
  logic             isrFound;
  logic [IDX_W-1:0] reqIdx;
  logic [IDX_W-1:0] isrIdx;

  // Downward scan so the lowest index (highest priority) is kept last.
  always_comb begin
    reqFound = 1'b0;
    isrFound = 1'b0;
    reqIdx   = '0;
    isrIdx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (req[i] && !mask[i]) begin
        reqFound = 1'b1;
        reqIdx   = IDX_W'(i);
      end
      if (inService[i]) begin
        isrFound = 1'b1;
        isrIdx   = IDX_W'(i);
      end
    end
  end

  assign valid  = reqFound && (!isrFound || (reqIdx < isrIdx));
  assign winIdx = reqIdx;

endmodule

// File: rtl/icDatapath.sv
module icDatapath import dic_pkg::*; #(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W    = $clog2(LINES),
  localparam int LINE_W   = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*LINES-1:0] reqIn,
  input  logic               maskWe,
  input  logic               maskSel,
  input  logic [LINES-1:0]   maskData,
  input  logic               baseWe,
  input  logic               baseSel,
  input  logic [VEC_W-1:0]   baseData,
  input  logic               eoiStb,
  input  logic               eoiSel,
  input  ackStrobe_t         strobe,
  output logic               masterValid,
  output logic [IDX_W-1:0]   masterIdx,
  output logic               slaveValid,
  output logic [VEC_W-1:0]   vecOut,
  output logic [LINE_W-1:0]  lineOut,
  output logic               vecValid
);

  localparam logic [LINES-1:0] CASC_BIT = LINES'(1) << CASC_LINE;

  logic [2*LINES-1:0] reqPrev;
  logic [LINES-1:0]   irrM, irrS, isrM, isrS, maskM, maskS;
  logic [VEC_W-1:0]   baseM, baseS;
  logic [LINES-1:0]   effMaskM, effMaskS, mReq;
  logic [IDX_W-1:0]   slaveIdx;
  logic [2*LINES-1:0] rise;
  logic [LINES-1:0]   mWinOh, sWinOh, lowIsrM, lowIsrS;
  logic [LINES-1:0]   clrIrrM, clrIrrS, setIsrM, setIsrS, clrIsrM, clrIsrS;

  // A mask write acts in the cycle it is presented.
  assign effMaskM = (maskWe && !maskSel) ? maskData : maskM;
  assign effMaskS = (maskWe &&  maskSel) ? maskData : maskS;

  // Cascade line of the first controller follows the second's winner.
  always_comb begin
    mReq            = irrM;
    mReq[CASC_LINE] = slaveValid;
  end

  icResolver #(.LINES(LINES)) u_resSlave (
    .req(irrS), .mask(effMaskS), .inService(isrS),
    .valid(slaveValid), .winIdx(slaveIdx)
  );

  icResolver #(.LINES(LINES)) u_resMaster (
    .req(mReq), .mask(effMaskM), .inService(isrM),
    .valid(masterValid), .winIdx(masterIdx)
  );

  assign rise    = reqIn & ~reqPrev;
  assign mWinOh  = LINES'(1) << masterIdx;
  assign sWinOh  = LINES'(1) << slaveIdx;
  assign lowIsrM = isrM & (~isrM + LINES'(1));
  assign lowIsrS = isrS & (~isrS + LINES'(1));

  always_comb begin
    clrIrrM = strobe.takeMaster ? mWinOh : '0;
    setIsrM = (strobe.takeMaster || strobe.enterCasc) ? mWinOh : '0;
    clrIrrS = strobe.takeSlave ? sWinOh : '0;
    setIsrS = strobe.takeSlave ? sWinOh : '0;
    clrIsrM = (eoiStb && !eoiSel) ? lowIsrM : '0;
    clrIsrS = (eoiStb &&  eoiSel) ? lowIsrS : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= '0;
      irrM    <= '0;
      irrS    <= '0;
      isrM    <= '0;
      isrS    <= '0;
      maskM   <= '0;
      maskS   <= '0;
      baseM   <= '0;
      baseS   <= '0;
    end else begin
      reqPrev <= reqIn;
      irrM    <= (irrM & ~clrIrrM) | (rise[LINES-1:0] & ~CASC_BIT);
      irrS    <= (irrS & ~clrIrrS) | rise[2*LINES-1:LINES];
      isrM    <= (isrM & ~clrIsrM) | setIsrM;
      isrS    <= (isrS & ~clrIsrS) | setIsrS;
      if (maskWe && !maskSel) maskM <= maskData;
      if (maskWe &&  maskSel) maskS <= maskData;
      if (baseWe && !baseSel) baseM <= baseData;
      if (baseWe &&  baseSel) baseS <= baseData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecOut   <= '0;
      lineOut  <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= strobe.takeMaster || strobe.spurMaster ||
                  strobe.takeSlave  || strobe.spurSlave;
      if (strobe.takeMaster) begin
        vecOut  <= baseM + VEC_W'(masterIdx);
        lineOut <= LINE_W'(masterIdx);
      end else if (strobe.spurMaster) begin
        vecOut  <= baseM + VEC_W'(LINES - 1);
        lineOut <= LINE_W'(LINES - 1);
      end else if (strobe.takeSlave) begin
        vecOut  <= baseS + VEC_W'(slaveIdx);
        lineOut <= LINE_W'(LINES) + LINE_W'(slaveIdx);
      end else if (strobe.spurSlave) begin
        vecOut  <= baseS + VEC_W'(LINES - 1);
        lineOut <= LINE_W'(2 * LINES - 1);
      end
    end
  end

  // R6: the acknowledged line is in service on the following cycle.
  a_r6_isr_set: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeMaster |=> isrM[$past(masterIdx)]);

  // R6, R9: an answer of the first controller is valid one cycle later.
  a_r6_vec_valid: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeMaster || strobe.spurMaster) |=> vecValid);

  // R9: a spurious answer of the first controller leaves in-service state alone.
  a_r9_spur_no_isr: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.spurMaster && !eoiStb) |=> (isrM == $past(isrM)) && (isrS == $past(isrS)));

  // R8: a spurious answer of the second controller sets none of its in-service bits.
  a_r8_spur_slave_no_isr: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.spurSlave && !eoiStb) |=> (isrS == $past(isrS)));

  // R12: end-of-interrupt retires exactly one in-service bit.
  a_r12_eoi_one: assert property (@(posedge clk) disable iff (!rstN)
    (eoiStb && !eoiSel && (|isrM) && !strobe.takeMaster && !strobe.enterCasc)
      |=> ($countones(isrM) == $countones($past(isrM)) - 1));

endmodule

// File: rtl/icControl.sv
module icControl import dic_pkg::*; #(
  parameter int LINES     = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intAck,
  input  logic             masterValid,
  input  logic [IDX_W-1:0] masterIdx,
  input  logic             slaveValid,
  output ackStrobe_t       strobe
);

  ackState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (intAck) begin
          if (!masterValid) begin
            strobe.spurMaster = 1'b1;
          end else if (masterIdx == IDX_W'(CASC_LINE)) begin
            strobe.enterCasc = 1'b1;
            nextState        = ST_CASC;
          end else begin
            strobe.takeMaster = 1'b1;
          end
        end
      end
      ST_CASC: begin
        if (slaveValid) strobe.takeSlave = 1'b1;
        else            strobe.spurSlave = 1'b1;
        nextState = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R7: only one acknowledge action per cycle.
  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R7: the second controller answers in the cycle after the hand-down.
  a_r7_casc_follow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enterCasc |=> (strobe.takeSlave || strobe.spurSlave));

  // R13: no fresh acknowledge is taken during the hand-down cycle.
  a_r13_no_new_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CASC) |-> !(strobe.takeMaster || strobe.spurMaster || strobe.enterCasc));

  // R5: a real answer from the first controller needs a winner there.
  a_r5_take_needs_winner: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeMaster || strobe.enterCasc) |-> masterValid);

endmodule

// File: rtl/cascaded_intc.sv
module cascaded_intc import dic_pkg::*; #(
  parameter int LINES     = 8,
  parameter int VEC_W     = 8,
  parameter int CASC_LINE = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*LINES-1:0]     reqIn,
  input  logic                   maskWe,
  input  logic                   maskSel,
  input  logic [LINES-1:0]       maskData,
  input  logic                   baseWe,
  input  logic                   baseSel,
  input  logic [VEC_W-1:0]       baseData,
  input  logic                   eoiStb,
  input  logic                   eoiSel,
  input  logic                   intAck,
  output logic                   cpuInt,
  output logic [VEC_W-1:0]       vecOut,
  output logic                   vecValid,
  output logic [$clog2(LINES):0] lineOut
);

  ackStrobe_t                 strobe;
  logic                       masterValid;
  logic                       slaveValid;
  logic [$clog2(LINES)-1:0]   masterIdx;

  icDatapath #(.LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .maskWe(maskWe), .maskSel(maskSel), .maskData(maskData),
    .baseWe(baseWe), .baseSel(baseSel), .baseData(baseData),
    .eoiStb(eoiStb), .eoiSel(eoiSel), .strobe(strobe),
    .masterValid(masterValid), .masterIdx(masterIdx), .slaveValid(slaveValid),
    .vecOut(vecOut), .lineOut(lineOut), .vecValid(vecValid)
  );

  icControl #(.LINES(LINES), .CASC_LINE(CASC_LINE)) u_ctl (
    .clk(clk), .rstN(rstN), .intAck(intAck),
    .masterValid(masterValid), .masterIdx(masterIdx), .slaveValid(slaveValid),
    .strobe(strobe)
  );

  assign cpuInt = masterValid;

endmodule

// File: tb/cascaded_intc_tb.sv
module cascaded_intc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] reqIn = '0;
  logic        maskWe = 1'b0, maskSel = 1'b0;
  logic [7:0]  maskData = '0;
  logic        baseWe = 1'b0, baseSel = 1'b0;
  logic [7:0]  baseData = '0;
  logic        eoiStb = 1'b0, eoiSel = 1'b0;
  logic        intAck = 1'b0;
  logic        cpuInt, vecValid;
  logic [7:0]  vecOut;
  logic [3:0]  lineOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cascaded_intc u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn),
    .maskWe(maskWe), .maskSel(maskSel), .maskData(maskData),
    .baseWe(baseWe), .baseSel(baseSel), .baseData(baseData),
    .eoiStb(eoiStb), .eoiSel(eoiSel), .intAck(intAck),
    .cpuInt(cpuInt), .vecOut(vecOut), .vecValid(vecValid), .lineOut(lineOut)
  );

  typedef struct packed {
    logic [7:0]  mMask;
    logic [7:0]  sMask;
    logic [7:0]  mBase;
    logic [7:0]  sBase;
    logic [15:0] lines;
    logic [7:0]  expVec;
    logic [3:0]  expLine;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t TABLE [NVEC] = '{
    '{8'h00, 8'h00, 8'h20, 8'h28, 16'h0060, 8'h25, 4'd5},
    '{8'h00, 8'h00, 8'h30, 8'h38, 16'h0202, 8'h31, 4'd1},
    '{8'h00, 8'h00, 8'h40, 8'h70, 16'h1008, 8'h74, 4'd12},
    '{8'h00, 8'h10, 8'h40, 8'h70, 16'h5000, 8'h76, 4'd14},
    '{8'h21, 8'h00, 8'h50, 8'h58, 16'h0061, 8'h56, 4'd6},
    '{8'h00, 8'h00, 8'h60, 8'h68, 16'h0014, 8'h64, 4'd4},
    '{8'h00, 8'h00, 8'hFC, 8'h08, 16'h0040, 8'h02, 4'd6}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqIn = '0; maskWe = 0; baseWe = 0; eoiStb = 0; intAck = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic setMask(input logic sel, input logic [7:0] d);
    @(negedge clk); maskWe = 1; maskSel = sel; maskData = d;
    @(negedge clk); maskWe = 0;
  endtask

  task automatic setBase(input logic sel, input logic [7:0] d);
    @(negedge clk); baseWe = 1; baseSel = sel; baseData = d;
    @(negedge clk); baseWe = 0;
  endtask

  task automatic pulse(input logic [15:0] l);
    @(negedge clk); reqIn = l;
    @(negedge clk); reqIn = '0;
  endtask

  task automatic eoi(input logic sel);
    @(negedge clk); eoiStb = 1; eoiSel = sel;
    @(negedge clk); eoiStb = 0;
  endtask

  task automatic doAck(output logic [7:0] v, output logic [3:0] ln, output int lat);
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0;
    lat = 1;
    while (!vecValid && lat < 5) begin
      @(negedge clk);
      lat++;
    end
    v = vecOut;
    ln = lineOut;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [3:0] ln;
    int lat;
    int pulses;

    // Table walk (R3, R4, R5, R6, R7, R11, R2: bit 2 ignored, 8-bit wrap)
    for (int k = 0; k < NVEC; k++) begin
      doReset();
      setMask(0, TABLE[k].mMask);
      setMask(1, TABLE[k].sMask);
      setBase(0, TABLE[k].mBase);
      setBase(1, TABLE[k].sBase);
      pulse(TABLE[k].lines);
      chk($sformatf("R5 table %0d cpuInt", k), 16'(cpuInt), 16'd1);
      doAck(v, ln, lat);
      chk($sformatf("R4 R6 R7 table %0d vector", k), 16'(v), 16'(TABLE[k].expVec));
      chk($sformatf("R4 R7 table %0d line", k), 16'(ln), 16'(TABLE[k].expLine));
      chk($sformatf("R6 R7 table %0d latency", k), 16'(lat),
          (TABLE[k].expLine >= 4'd8) ? 16'd2 : 16'd1);
    end

    // R1 reset state
    doReset();
    chk("R1 cpuInt", 16'(cpuInt), 16'd0);
    chk("R1 vecValid", 16'(vecValid), 16'd0);
    chk("R1 vecOut", 16'(vecOut), 16'd0);
    setBase(0, 8'h08);
    setBase(1, 8'h70);

    // R9 spurious on the first controller
    doAck(v, ln, lat);
    chk("R9 spurious vector", 16'(v), 16'h0F);
    chk("R9 spurious line", 16'(ln), 16'd7);
    pulse(16'h0040);
    chk("R9 no in-service set, line 6 delivers", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R9 line 6 vector", 16'(v), 16'h0E);
    eoi(0);

    // R4 nesting and R12 end-of-interrupt
    pulse(16'h0008);
    doAck(v, ln, lat);
    chk("R6 line 3 vector", 16'(v), 16'h0B);
    pulse(16'h0020);
    chk("R4 line 5 blocked by line 3 in service", 16'(cpuInt), 16'd0);
    pulse(16'h0002);
    chk("R4 line 1 outranks in-service line 3", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R6 line 1 vector", 16'(v), 16'h09);
    eoi(0);
    chk("R12 first EOI retires line 1 only", 16'(cpuInt), 16'd0);
    eoi(0);
    chk("R12 second EOI retires line 3", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R6 line 5 vector", 16'(v), 16'h0D);
    eoi(0);
    chk("R6 request cleared by acknowledge", 16'(cpuInt), 16'd0);

    // R2 held level is not latched again
    @(negedge clk); reqIn = 16'h0010;
    @(negedge clk);
    doAck(v, ln, lat);
    chk("R2 held line 4 vector", 16'(v), 16'h0C);
    eoi(0);
    chk("R2 held level not relatched", 16'(cpuInt), 16'd0);
    @(negedge clk); reqIn = '0;
    @(negedge clk); reqIn = 16'h0010;
    @(negedge clk); reqIn = '0;
    chk("R2 new rising edge latched", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    eoi(0);

    // R10 mask write on the first controller
    pulse(16'h0010);
    @(negedge clk); maskWe = 1; maskSel = 0; maskData = 8'h10;
    #1 chk("R10 cpuInt drops in write cycle", 16'(cpuInt), 16'd0);
    @(negedge clk); maskWe = 0;
    chk("R10 stays masked", 16'(cpuInt), 16'd0);
    setMask(0, 8'h00);
    chk("R10 unmask restores", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R10 line 4 vector", 16'(v), 16'h0C);
    eoi(0);

    // R3 and R10 through the cascade
    pulse(16'h0400);
    chk("R3 slave request raises cpuInt", 16'(cpuInt), 16'd1);
    @(negedge clk); maskWe = 1; maskSel = 1; maskData = 8'h04;
    #1 chk("R10 cascade withdrawn in write cycle", 16'(cpuInt), 16'd0);
    @(negedge clk); maskWe = 0;

    // R11 lower first-controller line while the second has no winner
    pulse(16'h0020);
    chk("R11 line 5 pending", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R11 line 5 vector", 16'(v), 16'h0D);
    chk("R11 line 5 latency", 16'(lat), 16'd1);
    eoi(0);
    setMask(1, 8'h00);
    chk("R3 unmasked slave line 10 pending", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R7 slave line 10 vector", 16'(v), 16'h72);
    chk("R7 slave line 10 number", 16'(ln), 16'd10);
    eoi(1);
    eoi(0);
    chk("R12 both controllers retired", 16'(cpuInt), 16'd0);

    // R8 spurious on the second controller
    pulse(16'h0800);
    @(negedge clk); intAck = 1;
    @(negedge clk); intAck = 0; maskWe = 1; maskSel = 1; maskData = 8'h08;
    @(negedge clk); maskWe = 0;
    chk("R8 vecValid", 16'(vecValid), 16'd1);
    chk("R8 slave spurious vector", 16'(vecOut), 16'h77);
    chk("R8 slave spurious line", 16'(lineOut), 16'd15);
    eoi(0);
    setMask(1, 8'h00);
    chk("R8 slave request still latched", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R8 slave line 11 vector", 16'(v), 16'h73);
    chk("R8 slave line 11 number", 16'(ln), 16'd11);
    eoi(1);
    eoi(0);

    // R13 acknowledge held across the hand-down cycle
    pulse(16'h0300);
    @(negedge clk); intAck = 1;
    @(negedge clk);
    @(negedge clk); intAck = 0;
    chk("R13 vecValid after cascade", 16'(vecValid), 16'd1);
    chk("R13 slave line 8 vector", 16'(vecOut), 16'h70);
    pulses = 0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (vecValid) pulses++;
    end
    chk("R13 extra acknowledge ignored", 16'(pulses), 16'd0);
    eoi(1);
    eoi(0);
    chk("R13 slave line 9 still pending", 16'(cpuInt), 16'd1);
    doAck(v, ln, lat);
    chk("R13 slave line 9 vector", 16'(v), 16'h71);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule